// File: doc/BRIEF.md
# PLL Control Register Bank with Per-Bit Write Enables

This block holds the configuration of one phase-locked loop in a small memory-mapped window of four 32-bit words. It turns the stored fields into static control lines for the PLL: the dividers, bypass, mode and power-down controls. It also feeds back the PLL's lock indication. A simple register bus reaches the block. The bus has a byte address, write data, a single-cycle write strobe and combinational read data.

The two lower words (offset 0x0 and offset 0x4) are half-word masked. Bits 31:16 of a write are not stored. Each of those upper bits is a per-bit enable for the matching lower bit, so software can change one field without reading the word first. The word at offset 0x8 is an ordinary 32-bit register, and every write replaces it whole. Offset 0xC and every address outside the window hold nothing. Word 0x4 bit 10 returns the lock input after a two-flip-flop synchronizer, and no write can change it.

The design has no sequencing of its own, so it has no state machine. Its flops are the three configuration words and the synchronizer chain. They are updated on each rising clock edge and cleared by an asynchronous active-low reset.

Top module: `pll_cfg_bank`

## Requirements
- R1: While reset is asserted, offset 0x0 reads 0x00009000 (bypass=1 at bit 15, post-divider 1 = 1 at bits 14:12, feedback divider 0 at bits 11:0). Offset 0x4 reads 0x00001041 (integer-mode bit 12 = 1, post-divider 2 = 1 at bits 8:6, reference divider = 1 at bits 5:0, lock bit 10 = 0 whatever the lock input is). Offset 0x8 reads 0.
- R2: A write to offset 0x0 changes bit n (n = 0..15) only when write-data bit n+16 is 1. The new value is taken from write-data bit n, and the change is visible after the next rising edge. All other bits keep their value.
- R3: A write to offset 0x4 follows the same per-bit enable rule for bits 15:12 and 8:0. Bits 11 and 9 always read 0.
- R4: Bits 31:16 of offsets 0x0 and 0x4 always read 0. Write-enable bits are never stored.
- R5: Offset 0x4 bit 10 reads the lock input delayed by two clock edges. A write to that bit has no effect, whatever its enable bit is.
- R6: A write to offset 0x8 replaces all 32 bits, with no masking. Bits 27, 26, 25 and 24 are the four-phase, VCO, post-divider and DAC power-downs, and bits 23:0 are the fractional divider.
- R7: The control outputs always equal the stored fields. Offset 0x0 gives bypass (15), post-divider 1 (14:12) and feedback divider (11:0). Offset 0x4 gives power-down select (15), power-down 1 (14), power-down 0 (13), integer mode (12), post-divider 2 (8:6) and reference divider (5:0). Offset 0x8 gives the fields named in R6.
- R8: Offset 0xC, any address with bits 1:0 not zero, and any address at or above 0x10 read as 0. A write to any of them changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| lock_in | input | 1 | Asynchronous lock indication from the PLL |
| ctl_bypass | output | 1 | Reference passed straight through |
| ctl_postdiv1 | output | 3 | First post-divider |
| ctl_fbdiv | output | 12 | Feedback divider |
| ctl_pd_sel | output | 1 | Power-down source select |
| ctl_pd1 | output | 1 | Power-down 1 |
| ctl_pd0 | output | 1 | Power-down 0 |
| ctl_int_mode | output | 1 | Sigma-delta off, integer mode |
| ctl_postdiv2 | output | 3 | Second post-divider |
| ctl_refdiv | output | 6 | Reference divider |
| ctl_pd_4ph | output | 1 | Four-phase output power-down |
| ctl_pd_vco | output | 1 | VCO output power-down |
| ctl_pd_post | output | 1 | Post-divider output power-down |
| ctl_pd_dac | output | 1 | DAC power-down |
| ctl_frac | output | 24 | Fractional divider |

## Verification
The bench builds the block with ADDR_W = 6 and SYNC_STAGES = 2. The six-bit address reaches offsets 0x10, 0x14 and 0x20, which would alias onto the live words if the decoder ignored the upper address bits. The two-stage chain fixes the lock delay at exactly two edges, so the bench model can compare bit 10 on every cycle. That includes the cycles in reset, when the lock input is held high.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    localparam logic [1:0] IDX_CTRL = 2'd0;
    localparam logic [1:0] IDX_DIV  = 2'd1;
    localparam logic [1:0] IDX_FRAC = 2'd2;
    localparam logic [1:0] IDX_RSVD = 2'd3;

    localparam logic [HALF_W-1:0] CTRL_KEEP = 16'hFFFF;
    localparam logic [HALF_W-1:0] CTRL_RST  = 16'h9000;
    localparam logic [HALF_W-1:0] DIV_KEEP  = 16'hF1FF;
    localparam logic [HALF_W-1:0] DIV_RST   = 16'h1041;
    localparam int                LOCK_POS  = 10;

    typedef struct packed {
        logic        bypass;
        logic [2:0]  postdiv1;
        logic [11:0] fbdiv;
    } ctrl_word_t;

    typedef struct packed {
        logic       pd_sel;
        logic       pd1;
        logic       pd0;
        logic       int_mode;
        logic       rsv_hi;
        logic       lock;
        logic       rsv_lo;
        logic [2:0] postdiv2;
        logic [5:0] refdiv;
    } div_word_t;

    typedef struct packed {
        logic [3:0]  spare;
        logic        pd_4ph;
        logic        pd_vco;
        logic        pd_post;
        logic        pd_dac;
        logic [23:0] frac;
    } frac_word_t;

endpackage

// File: rtl/pll_cfg_decode.sv
module pll_cfg_decode #(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        sel
);
    localparam int NWORDS = 4;

    logic aligned;
    logic in_window;

    assign aligned = (addr[1:0] == 2'b00);

    generate
        if (ADDR_W > 4) begin : g_wide
            assign in_window = (addr[ADDR_W-1:4] == '0);
        end else begin : g_narrow
            assign in_window = 1'b1;
        end
    endgenerate

    generate
        for (genvar i = 0; i < NWORDS; i++) begin : g_sel
            assign sel[i] = aligned && in_window && (addr[3:2] == i[1:0]);
        end
    endgenerate
endmodule

// File: rtl/pll_cfg_hiword_reg.sv
module pll_cfg_hiword_reg #(
    parameter logic [15:0] RST  = 16'h0000,
    parameter logic [15:0] KEEP = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [31:0] wdata,
    output logic [15:0] q
);
    logic [15:0] en;
    logic [15:0] q_next;

    always_comb begin
        en     = wr ? wdata[31:16] : 16'h0000;
        q_next = ((q & ~en) | (wdata[15:0] & en)) & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST & KEEP;
        else        q <= q_next;
    end
endmodule

// File: rtl/pll_cfg_sync.sv
module pll_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pll_cfg_bank.sv
module pll_cfg_bank
    import pll_cfg_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              lock_in,
    output logic              ctl_bypass,
    output logic [2:0]        ctl_postdiv1,
    output logic [11:0]       ctl_fbdiv,
    output logic              ctl_pd_sel,
    output logic              ctl_pd1,
    output logic              ctl_pd0,
    output logic              ctl_int_mode,
    output logic [2:0]        ctl_postdiv2,
    output logic [5:0]        ctl_refdiv,
    output logic              ctl_pd_4ph,
    output logic              ctl_pd_vco,
    output logic              ctl_pd_post,
    output logic              ctl_pd_dac,
    output logic [23:0]       ctl_frac
);
    logic [3:0]        sel;
    logic [HALF_W-1:0] ctrl_q;
    logic [HALF_W-1:0] div_q;
    frac_word_t        frac_q;
    ctrl_word_t        ctrl_f;
    div_word_t         div_f;
    logic              lock_s;

    pll_cfg_decode #(.ADDR_W(ADDR_W)) i_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    pll_cfg_hiword_reg #(.RST(CTRL_RST), .KEEP(CTRL_KEEP)) i_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr && sel[IDX_CTRL]),
        .wdata (bus_wdata),
        .q     (ctrl_q)
    );

    pll_cfg_hiword_reg #(.RST(DIV_RST), .KEEP(DIV_KEEP)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr && sel[IDX_DIV]),
        .wdata (bus_wdata),
        .q     (div_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        frac_q <= '0;
        else if (bus_wr && sel[IDX_FRAC])  frac_q <= frac_word_t'(bus_wdata);
    end

    pll_cfg_sync #(.STAGES(SYNC_STAGES)) i_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (lock_in),
        .q     (lock_s)
    );

    always_comb begin
        ctrl_f      = ctrl_word_t'(ctrl_q);
        div_f       = div_word_t'(div_q);
        div_f.lock  = lock_s;
    end

    always_comb begin
        bus_rdata = '0;
        unique if (sel[IDX_CTRL]) bus_rdata = {16'h0000, ctrl_f};
        else if   (sel[IDX_DIV])  bus_rdata = {16'h0000, div_f};
        else if   (sel[IDX_FRAC]) bus_rdata = frac_q;
        else                      bus_rdata = '0;
    end

    assign ctl_bypass   = ctrl_f.bypass;
    assign ctl_postdiv1 = ctrl_f.postdiv1;
    assign ctl_fbdiv    = ctrl_f.fbdiv;
    assign ctl_pd_sel   = div_f.pd_sel;
    assign ctl_pd1      = div_f.pd1;
    assign ctl_pd0      = div_f.pd0;
    assign ctl_int_mode = div_f.int_mode;
    assign ctl_postdiv2 = div_f.postdiv2;
    assign ctl_refdiv   = div_f.refdiv;
    assign ctl_pd_4ph   = frac_q.pd_4ph;
    assign ctl_pd_vco   = frac_q.pd_vco;
    assign ctl_pd_post  = frac_q.pd_post;
    assign ctl_pd_dac   = frac_q.pd_dac;
    assign ctl_frac     = frac_q.frac;
endmodule

// File: rtl/pll_cfg_bank_chk.sv
module pll_cfg_bank_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              lock_in,
    input logic              ctl_bypass,
    input logic [2:0]        ctl_postdiv1,
    input logic [11:0]       ctl_fbdiv,
    input logic              ctl_pd_sel,
    input logic              ctl_pd1,
    input logic              ctl_pd0,
    input logic              ctl_int_mode,
    input logic [2:0]        ctl_postdiv2,
    input logic [5:0]        ctl_refdiv,
    input logic              ctl_pd_4ph,
    input logic              ctl_pd_vco,
    input logic              ctl_pd_post,
    input logic              ctl_pd_dac,
    input logic [23:0]       ctl_frac
);
    logic [15:0] ctrl_v;
    logic [12:0] div_v;
    logic [27:0] frac_v;
    logic [1:0]  age;
    logic        at0, at4, at8, unmapped;

    assign ctrl_v   = {ctl_bypass, ctl_postdiv1, ctl_fbdiv};
    assign div_v    = {ctl_pd_sel, ctl_pd1, ctl_pd0, ctl_int_mode, ctl_postdiv2, ctl_refdiv};
    assign frac_v   = {ctl_pd_4ph, ctl_pd_vco, ctl_pd_post, ctl_pd_dac, ctl_frac};
    assign at0      = (bus_addr == ADDR_W'(0));
    assign at4      = (bus_addr == ADDR_W'(4));
    assign at8      = (bus_addr == ADDR_W'(8));
    assign unmapped = !(at0 || at4 || at8);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    AST_CTRL_MASKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at0) |=> ctrl_v == (($past(ctrl_v) & ~$past(bus_wdata[31:16]))
                                     | ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16])))); // R2

    AST_UPPER_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (at0 || at4) |-> bus_rdata[31:16] == 16'h0000); // R4

    AST_LOCK_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (at4 && age == 2'd2) |-> bus_rdata[10] == $past(lock_in, 2)); // R5

    AST_FRAC_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at8) |=> frac_v == $past(bus_wdata[27:0])); // R6

    AST_UNMAPPED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && unmapped) |=> ($stable(ctrl_v) && $stable(div_v) && $stable(frac_v))); // R8

    AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> bus_rdata == 32'h0); // R8
endmodule

bind pll_cfg_bank pll_cfg_bank_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .lock_in      (lock_in),
    .ctl_bypass   (ctl_bypass),
    .ctl_postdiv1 (ctl_postdiv1),
    .ctl_fbdiv    (ctl_fbdiv),
    .ctl_pd_sel   (ctl_pd_sel),
    .ctl_pd1      (ctl_pd1),
    .ctl_pd0      (ctl_pd0),
    .ctl_int_mode (ctl_int_mode),
    .ctl_postdiv2 (ctl_postdiv2),
    .ctl_refdiv   (ctl_refdiv),
    .ctl_pd_4ph   (ctl_pd_4ph),
    .ctl_pd_vco   (ctl_pd_vco),
    .ctl_pd_post  (ctl_pd_post),
    .ctl_pd_dac   (ctl_pd_dac),
    .ctl_frac     (ctl_frac)
);

// File: tb/test_pll_cfg_bank.sv
`timescale 1ns/1ps
module test_pll_cfg_bank;
    localparam int ADDR_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              lock_in = 1'b0;
    logic              ctl_bypass, ctl_pd_sel, ctl_pd1, ctl_pd0, ctl_int_mode;
    logic [2:0]        ctl_postdiv1, ctl_postdiv2;
    logic [11:0]       ctl_fbdiv;
    logic [5:0]        ctl_refdiv;
    logic              ctl_pd_4ph, ctl_pd_vco, ctl_pd_post, ctl_pd_dac;
    logic [23:0]       ctl_frac;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [31:0] m_w0, m_w1, m_w2;
    logic        m_s1, m_s2;
    logic        rst_req = 1'b0;

    always #2 clk = ~clk;

    pll_cfg_bank #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) i_pll_cfg_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_in(lock_in),
        .ctl_bypass(ctl_bypass), .ctl_postdiv1(ctl_postdiv1), .ctl_fbdiv(ctl_fbdiv),
        .ctl_pd_sel(ctl_pd_sel), .ctl_pd1(ctl_pd1), .ctl_pd0(ctl_pd0),
        .ctl_int_mode(ctl_int_mode), .ctl_postdiv2(ctl_postdiv2), .ctl_refdiv(ctl_refdiv),
        .ctl_pd_4ph(ctl_pd_4ph), .ctl_pd_vco(ctl_pd_vco), .ctl_pd_post(ctl_pd_post),
        .ctl_pd_dac(ctl_pd_dac), .ctl_frac(ctl_frac)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [ADDR_W-1:0] a);
        case (a)
            6'd0:    return m_w0 & 32'h0000FFFF;
            6'd4:    return (m_w1 & 32'h0000F1FF) | (32'(m_s2) << 10);
            6'd8:    return m_w2;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] apply_mask(input logic [31:0] old, input logic [31:0] d);
        logic [31:0] m;
        m = d >> 16;
        return ((old & ~m) | (d & m)) & 32'h0000FFFF;
    endfunction

    task automatic model_reset();
        m_w0 = 32'h00009000; m_w1 = 32'h00001041; m_w2 = 32'h0;
        m_s1 = 1'b0; m_s2 = 1'b0;
    endtask

    task automatic compare_all(input logic in_rst);
        logic [31:0] exp;
        string t;
        exp = model_read(bus_addr);
        if (in_rst)               t = "R1";
        else if (bus_addr == 0)   t = "R2";
        else if (bus_addr == 4)   t = "R3";
        else if (bus_addr == 8)   t = "R6";
        else                      t = "R8";
        check(t, bus_rdata, exp);
        if (bus_addr == 0 || bus_addr == 4)
            check(in_rst ? "R1" : "R4", {16'h0, bus_rdata[31:16]}, 32'h0);
        if (bus_addr == 4)
            check(in_rst ? "R1" : "R5", {31'h0, bus_rdata[10]}, {31'h0, m_s2});
        check(in_rst ? "R1" : "R7", {16'h0, ctl_bypass, ctl_postdiv1, ctl_fbdiv}, m_w0 & 32'hFFFF);
        check(in_rst ? "R1" : "R7",
              {19'h0, ctl_pd_sel, ctl_pd1, ctl_pd0, ctl_int_mode, ctl_postdiv2, ctl_refdiv},
              {19'h0, m_w1[15:12], m_w1[8:0]});
        check(in_rst ? "R1" : "R7",
              {4'h0, ctl_pd_4ph, ctl_pd_vco, ctl_pd_post, ctl_pd_dac, ctl_frac}, {4'h0, m_w2[27:0]});
    endtask

    task automatic cyc(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                       input logic w, input logic lk);
        @(negedge clk);
        rst_n = rst_req; bus_addr = a; bus_wdata = d; bus_wr = w; lock_in = lk;
        #1;
        compare_all(!rst_n);
        @(posedge clk);
        if (rst_n) begin
            if (w && a == 0) m_w0 = apply_mask(m_w0, d);
            else if (w && a == 4) m_w1 = apply_mask(m_w1, d) & 32'h0000F1FF;
            else if (w && a == 8) m_w2 = d;
            m_s2 = m_s1;
            m_s1 = lk;
        end
    endtask

    initial begin
        int cnt = 0;
        while (!finished && cnt < 200000) begin
            @(posedge clk);
            cnt++;
        end
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] pick [9] = '{6'd0, 6'd4, 6'd8, 6'd12, 6'd1, 6'd2, 6'd16, 6'd20, 6'd32};
        model_reset();
        // R1: reset values with lock held high
        rst_req = 1'b0;
        cyc(6'd0, 32'hFFFF_FFFF, 1'b1, 1'b1);
        cyc(6'd4, 32'hFFFF_FFFF, 1'b1, 1'b1);
        cyc(6'd8, 32'hFFFF_FFFF, 1'b1, 1'b1);
        rst_req = 1'b1;
        cyc(6'd4, 32'h0, 1'b0, 1'b0);
        // R2: full mask, then partial mask, then zero mask
        cyc(6'd0, 32'hFFFF_2ABC, 1'b1, 1'b0);
        cyc(6'd0, 32'h00F0_FFFF, 1'b1, 1'b0);
        cyc(6'd0, 32'h0000_FFFF, 1'b1, 1'b0);
        cyc(6'd0, 32'h0, 1'b0, 1'b0);
        // R3/R5: word at 0x4, including bits 11..9 and the lock bit
        cyc(6'd4, 32'hFFFF_FFFF, 1'b1, 1'b1);
        cyc(6'd4, 32'h0E00_0000, 1'b1, 1'b1);
        cyc(6'd4, 32'h1000_0000, 1'b1, 1'b0);
        cyc(6'd4, 32'h0, 1'b0, 1'b0);
        cyc(6'd4, 32'h0, 1'b0, 1'b0);
        // R6: full-width write
        cyc(6'd8, 32'hA5C3_1234, 1'b1, 1'b0);
        cyc(6'd8, 32'h0F00_00FF, 1'b1, 1'b0);
        cyc(6'd8, 32'h0, 1'b0, 1'b0);
        // R8: unmapped writes and reads
        cyc(6'd12, 32'hFFFF_FFFF, 1'b1, 1'b0);
        cyc(6'd16, 32'hFFFF_FFFF, 1'b1, 1'b0);
        cyc(6'd1,  32'hFFFF_FFFF, 1'b1, 1'b0);
        cyc(6'd32, 32'hFFFF_0000, 1'b1, 1'b0);
        cyc(6'd0, 32'h0, 1'b0, 1'b0);
        cyc(6'd4, 32'h0, 1'b0, 1'b0);
        cyc(6'd8, 32'h0, 1'b0, 1'b0);
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            cyc(pick[$urandom % 9], $urandom, 1'($urandom % 2), 1'($urandom % 2));
        end
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule